// File: doc/BRIEF.md
# Programmable-Resolution Angle Counter with Byte-Lane Bus

This block keeps a shaft angle as a binary up/down counter and publishes it on a parallel bus that can be tri-stated one byte at a time. Upstream logic sends single-cycle up or down step requests. Each accepted step moves the angle by one unit of the selected resolution. A fixed-width busy pulse frames every update. A holding latch copies the counter to the bus only when no busy pulse is active and the host is not holding the value.

The resolution pins choose 10, 12, 14 or 16 significant bits. This choice sets the bit position that one step changes. It also forces every bit below that position to read as zero. The host can set the hold input low to read a stable value while steps continue to accumulate, so no motion is lost. A zero-index flag reports when the significant part of the angle is all zeros.

Top module: `angle_track_if`

## Requirements
- R1: The resolution select `res_sel` = {B,A} chooses the step weight: 2'b00 selects 10 bits (step 64), 2'b01 selects 12 bits (step 16), 2'b10 selects 14 bits (step 4) and 2'b11 selects 16 bits (step 1).
- R2: Bits of `data_bus` below the selected resolution always read 0, even when the counter holds nonzero values there.
- R3: A step request with only `step_up` high adds one step and one with only `step_dn` high subtracts one. The result wraps modulo 2^16. Both inputs high in the same cycle has no effect and raises no busy pulse.
- R4: Each applied step raises `busy` for exactly BUSY_CYC clock cycles (default 100, which is 0.4 µs at 4 ns). The counter changes only on the edge where `busy` rises.
- R5: Step requests that arrive during a busy pulse are kept as a net pending count. They are applied one at a time, each with its own busy pulse, after the current pulse ends.
- R6: While `hold_n` is 0, the value on `data_bus` stays frozen and counting continues. After `hold_n` returns to 1 and no pulse is active, the bus shows the full accumulated angle.
- R7: The output latch never changes while `busy` is high. A capture wanted during a pulse happens after the pulse ends.
- R8: With `hi_oe_n` low, `data_bus[15:8]` is driven (bit 15 is the MSB, weight 180°, and each lower bit has half the weight of the bit above it). With `lo_oe_n` low, `data_bus[7:0]` is driven. An enable that is high puts its byte in high impedance.
- R9: `zero_idx` is 1 exactly when the counter masked to the selected resolution is zero.
- R10: After reset the angle is 0, `busy` is 0, `zero_idx` is 1 and the bus reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_up | input | 1 | Request one step upward |
| step_dn | input | 1 | Request one step downward |
| res_sel | input | 2 | Resolution select {B,A} |
| hold_n | input | 1 | Low freezes the output latch |
| hi_oe_n | input | 1 | Low drives the upper byte |
| lo_oe_n | input | 1 | Low drives the lower byte |
| data_bus | output | 16 | Latched, masked angle, tri-stated per byte |
| busy | output | 1 | High while an update pulse is in progress |
| zero_idx | output | 1 | High when the masked angle is zero |

## Verification
Single steps are tried at each of the four resolutions. This separates the four step weights and shows that the low bits are masked. Wrap-around below zero shows modulo behaviour, and a simultaneous up and down request shows cancellation. A burst of three back-to-back requests tells a pending count apart from a dropped one. Hold and mid-pulse samples show whether the latch tracks the counter or stays frozen. A run of random steps with random resolution changes, including changes to a coarser resolution that leave residue in the low bits, is compared with a reference angle in the bench.

// File: rtl/angle_pkg.sv
package angle_pkg;
   // Bit position that one step changes, for a 16-bit angle:
   // sel 0 -> 10 bits, 1 -> 12, 2 -> 14, 3 -> 16.
   function automatic int unsigned step_shift(input logic [1:0] sel);
      return 6 - 2 * int'(sel);
   endfunction

   function automatic logic [15:0] res_mask(input logic [1:0] sel);
      return 16'hFFFF << step_shift(sel);
   endfunction
endpackage

// File: rtl/step_arbiter.sv
module step_arbiter #(
   parameter int BUSY_CYC = 100,
   parameter int PEND_W   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_up,
   input  logic req_dn,
   output logic go,
   output logic go_up,
   output logic busy
);
   localparam int CNT_W    = $clog2(BUSY_CYC + 1);
   localparam int PEND_MAX = (1 << (PEND_W - 1)) - 1;

   logic [CNT_W-1:0]         busy_cnt;
   logic signed [PEND_W-1:0] pend_q, pend_d;
   logic signed [PEND_W:0]   delta, sum;
   logic                     idle;

   assign idle = (busy_cnt == '0);
   assign busy = !idle;

   always_comb begin
      delta = '0;
      if (req_up && !req_dn) delta = 1;
      else if (req_dn && !req_up) delta = -1;
   end

   always_comb begin
      go     = 1'b0;
      go_up  = 1'b0;
      pend_d = pend_q;
      sum    = PEND_W'(0);
      if (idle && pend_q != '0) begin
         go     = 1'b1;
         go_up  = (pend_q > 0);
         sum    = (PEND_W + 1)'(pend_q) - (go_up ? 1 : -1) + delta;
         pend_d = sum[PEND_W-1:0];
      end else if (idle && delta != '0) begin
         go    = 1'b1;
         go_up = (delta > 0);
      end else begin
         sum = (PEND_W + 1)'(pend_q) + delta;
         if (sum > PEND_MAX) pend_d = PEND_W'(PEND_MAX);
         else if (sum < -PEND_MAX) pend_d = PEND_W'(-PEND_MAX);
         else pend_d = sum[PEND_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_cnt <= '0;
         pend_q   <= '0;
      end else begin
         pend_q <= pend_d;
         if (go) busy_cnt <= CNT_W'(BUSY_CYC);
         else if (!idle) busy_cnt <= busy_cnt - 1'b1;
      end
   end
endmodule

// File: rtl/angle_counter.sv
module angle_counter
   import angle_pkg::*;
#(
   parameter int ANG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             go_up,
   input  logic [1:0]       res_sel,
   output logic [ANG_W-1:0] ang,
   output logic             zero
);
   logic [ANG_W-1:0] inc;

   assign inc  = ANG_W'(1) << step_shift(res_sel);
   assign zero = ((ang & ANG_W'(res_mask(res_sel))) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ang <= '0;
      else if (go) ang <= go_up ? ang + inc : ang - inc;
   end
endmodule

// File: rtl/lane_latch.sv
module lane_latch
   import angle_pkg::*;
#(
   parameter int ANG_W  = 16,
   parameter int LANE_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ANG_W-1:0]          ang,
   input  logic                      hold_n,
   input  logic                      busy,
   input  logic [1:0]                res_sel,
   input  logic [ANG_W/LANE_W-1:0]   oe_n,
   output logic [ANG_W-1:0]          latch_q,
   output logic [ANG_W-1:0]          bus
);
   localparam int LANES = ANG_W / LANE_W;

   logic [ANG_W-1:0] shown;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q <= '0;
      else if (hold_n && !busy) latch_q <= ang;
   end

   assign shown = latch_q & ANG_W'(res_mask(res_sel));

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign bus[g*LANE_W +: LANE_W] =
         oe_n[g] ? {LANE_W{1'bz}} : shown[g*LANE_W +: LANE_W];
   end
endmodule

// File: rtl/angle_track_if.sv
module angle_track_if #(
   parameter int ANG_W        = 16,
   parameter int LANE_W       = 8,
   parameter int BUSY_CYC     = 100,
   parameter int CLK_PS       = 4000,
   parameter int PEND_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_up,
   input  logic             step_dn,
   input  logic [1:0]       res_sel,
   input  logic             hold_n,
   input  logic             hi_oe_n,
   input  logic             lo_oe_n,
   output logic [ANG_W-1:0] data_bus,
   output logic             busy,
   output logic             zero_idx
);
   localparam int LANES    = ANG_W / LANE_W;
   localparam int PULSE_PS = BUSY_CYC * CLK_PS;

   if (ANG_W != 16) begin : g_bad_width
      $error("angle_track_if: ANG_W must be 16");
   end
   if (LANES != 2 || LANES * LANE_W != ANG_W) begin : g_bad_lane
      $error("angle_track_if: angle must split into two byte lanes");
   end
   if (PULSE_PS < 250000 || PULSE_PS > 750000) begin : g_bad_pulse
      $error("angle_track_if: busy pulse must span 0.25 to 0.75 us");
   end
   if (PEND_W < 2) begin : g_bad_pend
      $error("angle_track_if: PEND_W must be at least 2");
   end

   logic             go, go_up;
   logic [ANG_W-1:0] ang_q, latch_q;

   step_arbiter #(.BUSY_CYC(BUSY_CYC), .PEND_W(PEND_W)) i_arb (
      .clk(clk), .rst_n(rst_n), .req_up(step_up), .req_dn(step_dn),
      .go(go), .go_up(go_up), .busy(busy)
   );

   angle_counter #(.ANG_W(ANG_W)) i_cnt (
      .clk(clk), .rst_n(rst_n), .go(go), .go_up(go_up),
      .res_sel(res_sel), .ang(ang_q), .zero(zero_idx)
   );

   lane_latch #(.ANG_W(ANG_W), .LANE_W(LANE_W)) i_lat (
      .clk(clk), .rst_n(rst_n), .ang(ang_q), .hold_n(hold_n),
      .busy(busy), .res_sel(res_sel), .oe_n({hi_oe_n, lo_oe_n}),
      .latch_q(latch_q), .bus(data_bus)
   );
endmodule

// File: rtl/angle_track_chk.sv
module angle_track_chk #(
   parameter int ANG_W    = 16,
   parameter int BUSY_CYC = 100
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             hold_n,
   input logic [1:0]       res_sel,
   input logic [ANG_W-1:0] ang_q,
   input logic [ANG_W-1:0] latch_q
);
   int unsigned      busy_run;
   logic [ANG_W-1:0] step_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_run <= 0;
      else if (busy) busy_run <= busy_run + 1;
      else busy_run <= 0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) step_w <= ANG_W'(1);
      else step_w <= ANG_W'(1) << (6 - 2 * int'(res_sel));
   end

   // R4: counter moves only when busy rises
   a_r4_update_framed: assert property (@(posedge clk) disable iff (!rst_n)
      (ang_q != $past(ang_q)) |-> $rose(busy));

   // R4: pulse width
   a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_run == BUSY_CYC));

   // R3, R1: a change is exactly one step of the selected weight
   a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      (ang_q != $past(ang_q)) |->
         ((ang_q - $past(ang_q)) == step_w || ($past(ang_q) - ang_q) == step_w));

   // R6: hold freezes latch
   a_r6_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_n |=> $stable(latch_q));

   // R7: no capture during busy
   a_r7_no_capture_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(latch_q));
endmodule

bind angle_track_if angle_track_chk #(.ANG_W(ANG_W), .BUSY_CYC(BUSY_CYC)) i_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .hold_n(hold_n),
   .res_sel(res_sel), .ang_q(ang_q), .latch_q(latch_q)
);

// File: tb/test_angle_track_if.sv
`timescale 1ns/1ps
module test_angle_track_if;
   localparam int BUSY_CYC = 100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        step_up = 1'b0, step_dn = 1'b0, hold_n = 1'b1;
   logic        hi_oe_n = 1'b0, lo_oe_n = 1'b0;
   logic [1:0]  res_sel = 2'b11;
   wire  [15:0] bus;
   logic        busy, zero_idx;

   int checks = 0, fails = 0;
   logic [15:0] ref_ang = '0;

   always #2 clk = ~clk;

   angle_track_if #(.BUSY_CYC(BUSY_CYC)) i_angle_track_if (
      .clk(clk), .rst_n(rst_n), .step_up(step_up), .step_dn(step_dn),
      .res_sel(res_sel), .hold_n(hold_n), .hi_oe_n(hi_oe_n),
      .lo_oe_n(lo_oe_n), .data_bus(bus), .busy(busy), .zero_idx(zero_idx)
   );

   function automatic logic [15:0] msk(input logic [1:0] r);
      return 16'hFFFF << (6 - 2 * int'(r));
   endfunction

   function automatic logic [15:0] stp(input logic [1:0] r);
      return 16'd1 << (6 - 2 * int'(r));
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic settle();
      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic step(input logic up, input logic dn);
      step_up = up; step_dn = dn;
      @(negedge clk);
      step_up = 1'b0; step_dn = 1'b0;
      if (up && !dn) ref_ang = ref_ang + stp(res_sel);
      else if (dn && !up) ref_ang = ref_ang - stp(res_sel);
   endtask

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int width, rises;
      logic [15:0] snap;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: reset state
      chk("R10 bus", bus, 16'h0000);
      chk("R10 busy", busy, 0);
      chk("R10 zero", zero_idx, 1);

      // R1/R2: step weights at every resolution
      for (int r = 3; r >= 0; r--) begin
         res_sel = r[1:0];
         step(1, 0);
         settle();
         chk("R1 step weight", bus, ref_ang & msk(res_sel));
      end
      // ref_ang = 1+4+16+64 = 85; 10-bit view = 64
      chk("R2 low bits masked", bus, 16'h0040);

      // R4: busy pulse width
      step(1, 0);
      width = 0;
      while (busy) begin width++; @(negedge clk); end
      chk("R4 busy width", width, BUSY_CYC);
      settle();

      // R3: both requests cancel, no busy
      snap = bus;
      step(1, 1);
      chk("R3 no busy on cancel", busy, 0);
      settle();
      chk("R3 cancel no change", bus, snap);

      // R3: wrap below zero at 10 bits
      res_sel = 2'b11;
      while (ref_ang != 0) begin step(0, 1); settle(); end
      chk("R9 zero at origin", zero_idx, 1);
      res_sel = 2'b00;
      step(0, 1);
      settle();
      chk("R3 wrap", bus, 16'hFFC0);
      chk("R9 nonzero", zero_idx, 0);
      step(1, 0);
      settle();
      chk("R3 wrap back", bus, 16'h0000);

      // R9: residue in low bits masked to zero
      res_sel = 2'b11;
      step(1, 0);
      settle();
      chk("R9 fine nonzero", zero_idx, 0);
      res_sel = 2'b00;
      @(negedge clk);
      chk("R9 coarse zero", zero_idx, 1);
      chk("R2 coarse bus", bus, 16'h0000);

      // R5: burst of three during busy
      res_sel = 2'b01;
      rises = 0;
      step(1, 0); step(1, 0); step(1, 0);
      rises = 1;
      for (int i = 0; i < 3 * (BUSY_CYC + 3); i++) begin
         logic pb;
         pb = busy;
         @(negedge clk);
         if (busy && !pb) rises++;
      end
      settle();
      chk("R5 three pulses", rises, 3);
      chk("R5 no count lost", bus, ref_ang & msk(res_sel));

      // R7: latch frozen during pulse
      snap = bus;
      step(1, 0);
      repeat (10) @(negedge clk);
      chk("R7 busy high", busy, 1);
      chk("R7 frozen in pulse", bus, snap);
      settle();
      chk("R7 captured after", bus, ref_ang & msk(res_sel));

      // R6: hold freezes, counting continues
      hold_n = 1'b0;
      @(negedge clk);
      snap = bus;
      step(1, 0); settle();
      step(1, 0); settle();
      chk("R6 held", bus, snap);
      hold_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R6 released", bus, ref_ang & msk(res_sel));

      // R8: byte enables
      res_sel = 2'b11;
      step(1, 0); settle();
      hi_oe_n = 1'b1;
      #0.1;
      chk("R8 upper hiz", bus[15:8] === 8'hzz, 1);
      chk("R8 lower driven", bus[7:0], ref_ang[7:0]);
      hi_oe_n = 1'b0; lo_oe_n = 1'b1;
      #0.1;
      chk("R8 lower hiz", bus[7:0] === 8'hzz, 1);
      chk("R8 upper driven", bus[15:8], ref_ang[15:8]);
      lo_oe_n = 1'b0;
      @(negedge clk);

      // random mix
      for (int i = 0; i < 60; i++) begin
         int u;
         res_sel = 2'($urandom % 4);
         u = $urandom % 3;
         step(u == 0 || u == 2, u == 1 || u == 2);
         settle();
         chk("R1 R3 random angle", bus, ref_ang & msk(res_sel));
         chk("R9 random zero", zero_idx, (ref_ang & msk(res_sel)) == 0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule